// File: doc/BRIEF.md
# Array Write Address Decoder

This block sits in front of the storage of a ternary-CAM search engine. It takes the address word of a WRITE command and decodes where the write goes. A 2-bit target field selects one of three destinations: an internal control register, the data array or the mask array.

Register writes take their address from the low bits of the word. Array writes ignore the low address bits of the word. They use a 15-bit burst pointer held inside the block instead. Data writes and mask writes share this pointer, and it steps by one after every array access.

The block outputs one-cycle write strobes, the resolved address and the write data. All of these are registered, so they appear one clock after the command is accepted. A register write aimed at a dedicated register address reloads the burst pointer. A target code that names no destination raises a one-cycle error strobe.

Top module: `cam_wr_addr_dec`

## Requirements
- R1: After reset all strobes (`reg_we`, `data_we`, `mask_we`, `id_err`) are low and the burst pointer is 0, so the first array write after reset uses address 0.
- R2: With `cmd_valid` high and target bits [20:19] = 2'b11, `reg_we` pulses one cycle later and `wr_addr` equals bits [5:0] of the address word, zero-extended to 15 bits.
- R3: With `cmd_valid` high and target bits = 2'b00, `data_we` pulses one cycle later and `wr_addr` equals the current burst pointer.
- R4: With `cmd_valid` high and target bits = 2'b01, `mask_we` pulses one cycle later and `wr_addr` equals the current burst pointer.
- R5: Every accepted data or mask write advances the shared burst pointer by one, so consecutive array writes of either kind get consecutive addresses.
- R6: The burst pointer wraps from 0x7FFF to 0x0000.
- R7: For array writes, bits [14:0] and the reserved bits of the address word have no effect on the result. For register writes, bits [18:6] and [67:21] have no effect.
- R8: Target bits = 2'b10 with `cmd_valid` high give an `id_err` pulse one cycle later. No write strobe fires and the burst pointer is left unchanged.
- R9: A register write to register address 0x2A loads the burst pointer from bits [14:0] of the write data. A register write to any other address leaves the pointer unchanged.
- R10: While `cmd_valid` is low, no strobe fires and the burst pointer holds its value.
- R11: `wr_data_out` is the write data presented with the accepted command, delayed by one cycle.
- R12: At most one of `reg_we`, `data_we`, `mask_we` and `id_err` is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Qualifies the write command in this cycle |
| addr_word | input | 68 | Address word of the WRITE command |
| wr_data_in | input | 68 | Write data of the command |
| reg_we | output | 1 | Internal register write strobe |
| data_we | output | 1 | Data array write strobe |
| mask_we | output | 1 | Mask array write strobe |
| id_err | output | 1 | Invalid target code strobe |
| wr_addr | output | 15 | Resolved write address |
| wr_data_out | output | 68 | Registered write data |

## Verification
The strobes, `wr_addr`, `wr_data_out` and `id_err` all come from one register stage. Each of them is therefore due exactly one clock after the edge that accepts the command.

A change to the burst pointer shows up only in the address of the next array write. This covers a load, a step or a deliberate non-change. Each check therefore issues a probe data or mask write and reads the address one cycle after that probe.

The bench drives inputs on the falling edge and holds them across one rising edge. It reads the outputs at the following falling edge, half a period after they were registered. It then checks on the next falling edge that the strobes have dropped again.

// File: rtl/wad_pkg.sv
package wad_pkg;
   typedef enum logic [1:0] {
      TGT_DATA = 2'b00,
      TGT_MASK = 2'b01,
      TGT_BAD  = 2'b10,
      TGT_REG  = 2'b11
   } wad_tgt_e;

   function automatic wad_tgt_e wad_decode_tgt(input logic [1:0] code);
      return wad_tgt_e'(code);
   endfunction
endpackage

// File: rtl/wad_classify.sv
module wad_classify
   import wad_pkg::*;
#(
   parameter int ADDR_W     = 68,
   parameter int ID_LSB     = 19,
   parameter int REG_ADDR_W = 6
) (
   input  logic                  cmd_valid,
   input  logic [ADDR_W-1:0]     addr_word,
   output logic                  go_reg,
   output logic                  go_data,
   output logic                  go_mask,
   output logic                  go_bad,
   output logic [REG_ADDR_W-1:0] reg_addr
);
   localparam int ID_MSB = ID_LSB + 1;

   wad_tgt_e tgt;
   logic     unused_bits;

   assign unused_bits = ^addr_word;
   assign tgt         = wad_decode_tgt(addr_word[ID_MSB:ID_LSB]);
   assign reg_addr    = addr_word[REG_ADDR_W-1:0];

   always_comb begin
      go_reg  = 1'b0;
      go_data = 1'b0;
      go_mask = 1'b0;
      go_bad  = 1'b0;
      if (cmd_valid) begin
         unique case (tgt)
            TGT_REG:  go_reg  = 1'b1;
            TGT_DATA: go_data = 1'b1;
            TGT_MASK: go_mask = 1'b1;
            default:  go_bad  = 1'b1;
         endcase
      end
   end

   always_comb begin
      a_excl_r12: assert ($onehot0({go_reg, go_data, go_mask, go_bad}));
   end
endmodule

// File: rtl/wad_burst_ctr.sv
module wad_burst_ctr #(
   parameter int BURST_W = 15
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               inc,
   input  logic               load,
   input  logic [BURST_W-1:0] load_val,
   output logic [BURST_W-1:0] cnt
);
   localparam logic [BURST_W-1:0] TOP = {BURST_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (load) cnt <= load_val;
      else if (inc)  cnt <= cnt + 1'b1;
   end

   p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load) |=> cnt == $past(cnt) + 1'b1);
   p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (inc && !load && cnt == TOP) |=> cnt == '0);
   p_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> cnt == $past(load_val));
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!inc && !load) |=> $stable(cnt));
endmodule

// File: rtl/wad_out_stage.sv
module wad_out_stage #(
   parameter int REG_ADDR_W = 6,
   parameter int BURST_W    = 15,
   parameter int DATA_W     = 68
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  go_reg,
   input  logic                  go_data,
   input  logic                  go_mask,
   input  logic                  go_bad,
   input  logic [REG_ADDR_W-1:0] reg_addr,
   input  logic [BURST_W-1:0]    burst_addr,
   input  logic [DATA_W-1:0]     data_in,
   output logic                  reg_we,
   output logic                  data_we,
   output logic                  mask_we,
   output logic                  id_err,
   output logic [BURST_W-1:0]    wr_addr,
   output logic [DATA_W-1:0]     data_out
);
   logic [BURST_W-1:0] reg_addr_ext;
   logic [BURST_W-1:0] addr_nxt;

   generate
      if (REG_ADDR_W == BURST_W) begin : g_pad_none
         assign reg_addr_ext = reg_addr;
      end else begin : g_pad_zero
         assign reg_addr_ext = {{(BURST_W-REG_ADDR_W){1'b0}}, reg_addr};
      end
   endgenerate

   assign addr_nxt = go_reg ? reg_addr_ext : burst_addr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reg_we   <= 1'b0;
         data_we  <= 1'b0;
         mask_we  <= 1'b0;
         id_err   <= 1'b0;
         wr_addr  <= '0;
         data_out <= '0;
      end else begin
         reg_we   <= go_reg;
         data_we  <= go_data;
         mask_we  <= go_mask;
         id_err   <= go_bad;
         wr_addr  <= addr_nxt;
         data_out <= data_in;
      end
   end

   p_onehot_r12: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({reg_we, data_we, mask_we, id_err}));
   p_regaddr_r2: assert property (@(posedge clk) disable iff (!rst_n)
      go_reg |=> wr_addr == $past(reg_addr_ext));
   p_arraddr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (go_data || go_mask) |=> wr_addr == $past(burst_addr));
   p_data_r11: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> data_out == $past(data_in));
endmodule

// File: rtl/cam_wr_addr_dec.sv
module cam_wr_addr_dec #(
   parameter int          ADDR_W        = 68,
   parameter int          DATA_W        = 68,
   parameter int          ID_LSB        = 19,
   parameter int          REG_ADDR_W    = 6,
   parameter int          BURST_W       = 15,
   parameter logic [5:0]  BURST_REG_SEL = 6'h2A
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic [ADDR_W-1:0] addr_word,
   input  logic [DATA_W-1:0] wr_data_in,
   output logic              reg_we,
   output logic              data_we,
   output logic              mask_we,
   output logic              id_err,
   output logic [BURST_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data_out
);
   localparam int ID_MSB = ID_LSB + 1;

   generate
      if (ID_MSB >= ADDR_W) begin : g_chk_id
         $error("target field lies outside the address word");
      end
      if (REG_ADDR_W > BURST_W || REG_ADDR_W > ID_LSB) begin : g_chk_reg
         $error("register address field too wide");
      end
      if (BURST_W > DATA_W) begin : g_chk_data
         $error("write data narrower than burst pointer");
      end
      if (REG_ADDR_W < 6 && BURST_REG_SEL >= (6'd1 << REG_ADDR_W)) begin : g_chk_sel
         $error("burst load selector not reachable");
      end
   endgenerate

   logic                  go_reg, go_data, go_mask, go_bad;
   logic [REG_ADDR_W-1:0] reg_addr;
   logic [BURST_W-1:0]    burst_cnt;
   logic                  burst_inc, burst_load;

   wad_classify #(
      .ADDR_W     (ADDR_W),
      .ID_LSB     (ID_LSB),
      .REG_ADDR_W (REG_ADDR_W)
   ) u_cls (
      .cmd_valid (cmd_valid),
      .addr_word (addr_word),
      .go_reg    (go_reg),
      .go_data   (go_data),
      .go_mask   (go_mask),
      .go_bad    (go_bad),
      .reg_addr  (reg_addr)
   );

   assign burst_inc  = go_data | go_mask;
   assign burst_load = go_reg && (reg_addr == BURST_REG_SEL[REG_ADDR_W-1:0]);

   wad_burst_ctr #(
      .BURST_W (BURST_W)
   ) u_ctr (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (burst_inc),
      .load     (burst_load),
      .load_val (wr_data_in[BURST_W-1:0]),
      .cnt      (burst_cnt)
   );

   wad_out_stage #(
      .REG_ADDR_W (REG_ADDR_W),
      .BURST_W    (BURST_W),
      .DATA_W     (DATA_W)
   ) u_out (
      .clk        (clk),
      .rst_n      (rst_n),
      .go_reg     (go_reg),
      .go_data    (go_data),
      .go_mask    (go_mask),
      .go_bad     (go_bad),
      .reg_addr   (reg_addr),
      .burst_addr (burst_cnt),
      .data_in    (wr_data_in),
      .reg_we     (reg_we),
      .data_we    (data_we),
      .mask_we    (mask_we),
      .id_err     (id_err),
      .wr_addr    (wr_addr),
      .data_out   (wr_data_out)
   );

   p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_valid |=> !(reg_we || data_we || mask_we || id_err));
   p_bad_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && addr_word[ID_MSB:ID_LSB] == 2'b10) |=> id_err && $stable(burst_cnt));
   p_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && addr_word[ID_MSB:ID_LSB] == 2'b00) |=> data_we);
   p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && addr_word[ID_MSB:ID_LSB] == 2'b01) |=> mask_we);
   p_reg_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && addr_word[ID_MSB:ID_LSB] == 2'b11) |=> reg_we);
endmodule

// File: tb/tb_cam_wr_addr_dec.sv
module tb_cam_wr_addr_dec;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [67:0] addr_word = '0;
   logic [67:0] wr_data_in = '0;
   logic        reg_we, data_we, mask_we, id_err;
   logic [14:0] wr_addr;
   logic [67:0] wr_data_out;

   int n_chk = 0;
   int n_bad = 0;
   logic [14:0] exp_ptr = '0;

   always #10 clk = ~clk;

   cam_wr_addr_dec dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid),
      .addr_word(addr_word), .wr_data_in(wr_data_in),
      .reg_we(reg_we), .data_we(data_we), .mask_we(mask_we), .id_err(id_err),
      .wr_addr(wr_addr), .wr_data_out(wr_data_out)
   );

   task automatic check(input bit ok, input string req, input logic [67:0] act, input logic [67:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic logic [67:0] mk_word(input logic [1:0] id, input logic [14:0] low, input logic [67:0] junk);
      logic [67:0] w = junk;
      w[20:19] = id;
      w[14:0]  = low;
      return w;
   endfunction

   task automatic send(input logic v, input logic [67:0] a, input logic [67:0] d);
      cmd_valid = v; addr_word = a; wr_data_in = d;
      @(negedge clk);
      cmd_valid = 1'b0;
   endtask

   task automatic strobes(input logic [3:0] exp, input string req);
      check({reg_we, data_we, mask_we, id_err} == exp, req,
            {64'b0, reg_we, data_we, mask_we, id_err}, {64'b0, exp});
   endtask

   task automatic probe(input logic [1:0] id, input string req);
      send(1'b1, mk_word(id, 15'h5A5A, 68'hF_FFFF_FFFF_FFE0_0000), 68'h0);
      check(wr_addr == exp_ptr, req, {53'b0, wr_addr}, {53'b0, exp_ptr});
      exp_ptr = exp_ptr + 1'b1;
   endtask

   task automatic t_reset();
      strobes(4'b0000, "R1 strobes after reset");
      probe(2'b00, "R1 first array address");
   endtask

   task automatic t_reg();
      logic [67:0] d = 68'hA_BCDE_F012_3456_789A;
      send(1'b1, mk_word(2'b11, 15'h7FD5, 68'hD_EAD0_BEEF_CAFE_0000), d);
      strobes(4'b1000, "R2 reg strobe");
      check(wr_addr == 15'h0015, "R2 R7 reg address", {53'b0, wr_addr}, 68'h15);
      check(wr_data_out == d, "R11 data out", wr_data_out, d);
      @(negedge clk);
      strobes(4'b0000, "R2 pulse ends");
   endtask

   task automatic t_array();
      probe(2'b00, "R3 R7 data address");
      check(data_we, "R3 data strobe", {67'b0, data_we}, 68'h1);
      probe(2'b01, "R4 R5 mask address shared");
      check(mask_we, "R4 mask strobe", {67'b0, mask_we}, 68'h1);
      probe(2'b00, "R5 data after mask");
      probe(2'b01, "R5 mask again");
   endtask

   task automatic t_bad();
      send(1'b1, mk_word(2'b10, 15'h1234, '0), '0);
      strobes(4'b0001, "R8 err only");
      @(negedge clk);
      strobes(4'b0000, "R8 err one cycle");
      probe(2'b00, "R8 pointer kept");
   endtask

   task automatic t_idle();
      send(1'b0, mk_word(2'b00, 15'h0, '0), '0);
      strobes(4'b0000, "R10 idle data");
      send(1'b0, mk_word(2'b11, 15'h2A, '0), 68'h111);
      strobes(4'b0000, "R10 idle reg");
      probe(2'b01, "R10 pointer kept");
   endtask

   task automatic t_load();
      send(1'b1, mk_word(2'b11, 15'h0015, '0), 68'h1234);
      probe(2'b00, "R9 other reg no load");
      send(1'b1, mk_word(2'b11, 15'h002A, '0), 68'hF_0000_0000_0000_7FFE);
      check(wr_addr == 15'h2A, "R9 load reg address", {53'b0, wr_addr}, 68'h2A);
      exp_ptr = 15'h7FFE;
      probe(2'b00, "R9 loaded value");
      probe(2'b01, "R6 top value");
      probe(2'b00, "R6 wrapped to zero");
   endtask

   task automatic t_back2back();
      cmd_valid = 1'b1; addr_word = mk_word(2'b00, 15'h0, '0);
      @(negedge clk);
      check(wr_addr == exp_ptr, "R5 b2b first", {53'b0, wr_addr}, {53'b0, exp_ptr});
      exp_ptr = exp_ptr + 1'b1;
      addr_word = mk_word(2'b01, 15'h7FFF, '0);
      @(negedge clk);
      check(wr_addr == exp_ptr && mask_we, "R5 b2b second", {53'b0, wr_addr}, {53'b0, exp_ptr});
      exp_ptr = exp_ptr + 1'b1;
      cmd_valid = 1'b0;
      @(negedge clk);
      strobes(4'b0000, "R12 quiet after burst");
   endtask

   initial begin
      #(20 * 100000);
      n_chk++; n_bad++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_reg();
      t_array();
      t_bad();
      t_idle();
      t_load();
      t_back2back();
      @(negedge clk);
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule